// File: doc/BRIEF.md
# GF(16) Lane-Parallel Arithmetic Unit

This block treats a wide data word as a row of independent 4-bit lanes. Each lane holds one element of the binary extension field GF(2^4), reduced by the polynomial x^4+x+1 (binary 10011). A 2-bit opcode selects one operation, which is applied to every lane at once. The operations are field addition, field multiplication and doubling. Multiplication reads a 256-entry product table that is computed at elaboration time, so no shift-and-reduce datapath is built.

A caller presents `op_code`, `opnd_a` and `opnd_b` with `in_valid` high for one cycle. On the next rising edge the output stage captures the lane results. `out_valid` is high during the cycle that follows. The output stage is a two-state machine. `OS_EMPTY` means no fresh result is held. `OS_FULL` means the result register was loaded on the last edge. The transition `LOAD` (`in_valid` high) enters `OS_FULL` from either state. The transition `DRAIN` (`in_valid` low) returns the machine to `OS_EMPTY`. The result register changes only on `LOAD`.

Top module: `gf16_lane_array`

## Requirements
- R1: The word is split into DATA_W/4 lanes. Lane k occupies bits [4k+3:4k] of `opnd_a`, `opnd_b` and `res_data`. A lane's result depends only on the same lane of the operands.
- R2: Opcode 2'b00 (add) gives, in every lane, the bitwise XOR of the `opnd_a` and `opnd_b` lanes.
- R3: Opcode 2'b01 (multiply) gives, in every lane, the product of the two lanes modulo x^4+x+1. For example, 8 times 7 gives 13.
- R4: Multiplication is commutative. A lane value of 1 is the identity, and a lane value of 0 gives 0.
- R5: Opcode 2'b10 (double) adds each `opnd_a` lane to itself in the field, which gives 0 in every lane. `opnd_b` has no effect on the result.
- R6: Opcode 2'b11 is reserved and gives 0 in every lane.
- R7: When `in_valid` is high at an edge, `res_data` shows that operation's result and `out_valid` is high during the following cycle.
- R8: When `in_valid` is low at an edge, `res_data` keeps its previous value and `out_valid` is low during the following cycle, whatever the operands and opcode are.
- R9: While `rst_n` is low, `out_valid` is 0 and `res_data` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands and opcode are presented this cycle |
| op_code | input | 2 | 00 add, 01 multiply, 10 double, 11 reserved |
| opnd_a | input | DATA_W (256) | First operand, packed 4-bit lanes |
| opnd_b | input | DATA_W (256) | Second operand, packed 4-bit lanes |
| out_valid | output | 1 | `res_data` holds a result loaded on the last edge |
| res_data | output | DATA_W (256) | Registered lane results |

## Verification
Every result is due exactly one rising edge after the edge that samples `in_valid`. The lane logic has no register, and the result register plus the state flop add one cycle in total. The bench changes inputs on falling edges and compares outputs at the next falling edge. That is half a cycle after the single capturing edge, so `out_valid` and `res_data` are read in the cycle in which they are due. For the hold and ignored-input checks, the bench changes the inputs with `in_valid` low and reads the outputs one falling edge later, before it issues the next operation.

// File: rtl/gf16_pkg.sv
package gf16_pkg;

    localparam int LANE_W  = 4;
    localparam int TAB_N   = 1 << (2 * LANE_W);
    localparam int TAB_W   = TAB_N * LANE_W;
    localparam logic [6:0] RED_POLY = 7'b0010011;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_MUL = 2'b01,
        OP_DBL = 2'b10,
        OP_RSV = 2'b11
    } gf_op_e;

    typedef enum logic {
        OS_EMPTY = 1'b0,
        OS_FULL  = 1'b1
    } out_state_e;

    // carry-less product followed by reduction, used only to fill the table
    function automatic logic [3:0] clmul_reduce(input logic [3:0] x, input logic [3:0] y);
        logic [6:0] acc;
        acc = '0;
        for (int i = 0; i < 4; i++) begin
            if (y[i]) acc = acc ^ ({3'b000, x} << i);
        end
        for (int j = 6; j >= 4; j--) begin
            if (acc[j]) acc = acc ^ (RED_POLY << (j - 4));
        end
        return acc[3:0];
    endfunction

    // full product table packed as {x,y} -> 4-bit entry
    function automatic logic [TAB_W-1:0] build_prod_tab();
        logic [TAB_W-1:0] t;
        logic [7:0]       idx;
        t = '0;
        for (int k = 0; k < TAB_N; k++) begin
            idx = k[7:0];
            t[k*LANE_W +: LANE_W] = clmul_reduce(idx[7:4], idx[3:0]);
        end
        return t;
    endfunction

    localparam logic [TAB_W-1:0] PROD_TAB = build_prod_tab();

endpackage

// File: rtl/gf16_lane.sv
module gf16_lane
    import gf16_pkg::*;
(
    input  gf_op_e     op,
    input  logic [3:0] x,
    input  logic [3:0] y,
    output logic [3:0] z
);
    logic [7:0] tab_idx;
    logic [3:0] prod;
    logic [3:0] sum_xx;

    assign tab_idx = {x, y};
    assign prod    = PROD_TAB[tab_idx*LANE_W +: LANE_W];
    assign sum_xx  = x ^ x;

    always_comb begin
        unique case (op)
            OP_ADD:  z = x ^ y;
            OP_MUL:  z = prod;
            OP_DBL:  z = sum_xx;
            OP_RSV:  z = '0;
            default: z = '0;
        endcase
    end
endmodule

// File: rtl/gf16_out_stage.sv
module gf16_out_stage
    import gf16_pkg::*;
#(
    parameter int DATA_W = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] d,
    output logic              q_valid,
    output logic [DATA_W-1:0] q
);
    out_state_e state_q, state_d;

    always_comb begin
        unique case (state_q)
            OS_EMPTY: state_d = load ? OS_FULL : OS_EMPTY;
            OS_FULL:  state_d = load ? OS_FULL : OS_EMPTY;
            default:  state_d = OS_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OS_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end

    assign q_valid = (state_q == OS_FULL);
endmodule

// File: rtl/gf16_lane_array.sv
module gf16_lane_array
    import gf16_pkg::*;
#(
    parameter int DATA_W = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op_code,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] res_data
);
    localparam int LANES = DATA_W / LANE_W;

    gf_op_e            op_sel;
    logic [DATA_W-1:0] lane_res;

    assign op_sel = gf_op_e'(op_code);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        gf16_lane u_lane (
            .op (op_sel),
            .x  (opnd_a[k*LANE_W +: LANE_W]),
            .y  (opnd_b[k*LANE_W +: LANE_W]),
            .z  (lane_res[k*LANE_W +: LANE_W])
        );
    end

    gf16_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (in_valid),
        .d       (lane_res),
        .q_valid (out_valid),
        .q       (res_data)
    );
endmodule

// File: rtl/gf16_chk.sv
module gf16_chk #(
    parameter int DATA_W = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        op_code,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic              out_valid,
    input logic [DATA_W-1:0] res_data
);
    AST_ADD_XOR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == 2'b00) |=> (res_data == ($past(opnd_a) ^ $past(opnd_b)))); // R2

    AST_DBL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == 2'b10) |=> (res_data == '0)); // R5

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == 2'b11) |=> (res_data == '0)); // R6

    AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R7

    AST_IDLE_NOVALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(res_data)); // R8

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_CLEAR: assert (!out_valid && res_data == '0); // R9
        end
    end
endmodule

bind gf16_lane_array gf16_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_code   (op_code),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .out_valid (out_valid),
    .res_data  (res_data)
);

// File: tb/tb_gf16_lane_array.sv
`timescale 1ns/1ps
module tb_gf16_lane_array;
    localparam int DW = 256;
    localparam int NL = DW / 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    op_code = 2'b00;
    logic [DW-1:0] opnd_a = '0;
    logic [DW-1:0] opnd_b = '0;
    logic          out_valid;
    logic [DW-1:0] res_data;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    gf16_lane_array #(.DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid), .res_data(res_data)
    );

    // bench's own field product: shift-and-add, reduce by x^4+x+1
    function automatic logic [3:0] ref_mul(input logic [3:0] x, input logic [3:0] y);
        logic [3:0] acc, cur;
        acc = '0; cur = x;
        for (int i = 0; i < 4; i++) begin
            if (y[i]) acc = acc ^ cur;
            cur = cur[3] ? ({cur[2:0], 1'b0} ^ 4'b0011) : {cur[2:0], 1'b0};
        end
        return acc;
    endfunction

    function automatic logic [DW-1:0] ref_word(input logic [1:0] op,
                                               input logic [DW-1:0] a, input logic [DW-1:0] b);
        logic [DW-1:0] r;
        r = '0;
        for (int k = 0; k < NL; k++) begin
            case (op)
                2'b00:   r[k*4 +: 4] = a[k*4 +: 4] ^ b[k*4 +: 4];
                2'b01:   r[k*4 +: 4] = ref_mul(a[k*4 +: 4], b[k*4 +: 4]);
                default: r[k*4 +: 4] = 4'h0;
            endcase
        end
        return r;
    endfunction

    function automatic logic [DW-1:0] rnd_word();
        logic [DW-1:0] w;
        for (int i = 0; i < DW/32; i++) w[i*32 +: 32] = $urandom;
        return w;
    endfunction

    task automatic check_eq(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    // drive at a falling edge; result is due after one rising edge
    task automatic issue(input logic [1:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b);
        @(negedge clk);
        in_valid = 1'b1; op_code = op; opnd_a = a; opnd_b = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_check(input string tag, input logic [1:0] op,
                             input logic [DW-1:0] a, input logic [DW-1:0] b);
        issue(op, a, b);
        check_bit({tag, " valid"}, out_valid, 1'b1);
        check_eq(tag, res_data, ref_word(op, a, b));
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] a, b, first, ones, hold;
        logic [1:0]    op;
        void'($urandom(32'd20240611));

        // R9: reset state
        #23;
        check_bit("R9 out_valid in reset", out_valid, 1'b0);
        check_eq("R9 res_data in reset", res_data, '0);
        @(negedge clk); rst_n = 1'b1;

        // R3 directed: 8 * 7 = 13 in lane 0
        a = '0; b = '0; a[3:0] = 4'd8; b[3:0] = 4'd7;
        issue(2'b01, a, b);
        check_eq("R3 8x7", {252'd0, res_data[3:0]}, {252'd0, 4'd13});

        // R3 R1: all 256 input pairs, 64 per word, lane k carries pair w*64+k
        for (int w = 0; w < 4; w++) begin
            for (int k = 0; k < NL; k++) begin
                logic [7:0] pi;
                pi = 8'(w * NL + k);
                a[k*4 +: 4] = pi[7:4];
                b[k*4 +: 4] = pi[3:0];
            end
            run_check("R3 exhaustive", 2'b01, a, b);
            first = res_data;
            // R4: commutative
            issue(2'b01, b, a);
            check_eq("R4 commutative", res_data, first);
        end

        // R4: identity and zero
        ones = '0;
        for (int k = 0; k < NL; k++) ones[k*4 +: 4] = 4'h1;
        a = rnd_word();
        issue(2'b01, a, ones);
        check_eq("R4 identity", res_data, a);
        issue(2'b01, a, '0);
        check_eq("R4 zero", res_data, '0);

        // R1: single live lane, others zero
        for (int k = 0; k < NL; k += 21) begin
            a = '0; b = '0; a[k*4 +: 4] = 4'hB; b[k*4 +: 4] = 4'h6;
            run_check("R1 lone lane", 2'b01, a, b);
        end

        // R2: add, random
        for (int i = 0; i < 10; i++) run_check("R2 add", 2'b00, rnd_word(), rnd_word());

        // R5: double gives zero, b ignored
        issue(2'b00, rnd_word(), rnd_word());
        for (int i = 0; i < 5; i++) begin
            issue(2'b10, rnd_word(), rnd_word());
            check_eq("R5 double zero", res_data, '0);
        end

        // R6: reserved
        issue(2'b00, rnd_word(), rnd_word());
        issue(2'b11, rnd_word(), rnd_word());
        check_eq("R6 reserved zero", res_data, '0);

        // R8: hold while idle
        issue(2'b01, rnd_word(), rnd_word());
        hold = res_data;
        for (int i = 0; i < 4; i++) begin
            op_code = 2'($urandom); opnd_a = rnd_word(); opnd_b = rnd_word();
            @(negedge clk);
            check_bit("R8 idle valid low", out_valid, 1'b0);
            check_eq("R8 idle hold", res_data, hold);
        end

        // R7: back-to-back, each due one edge later
        @(negedge clk);
        for (int i = 0; i < 200; i++) begin
            op = 2'($urandom); a = rnd_word(); b = rnd_word();
            in_valid = 1'b1; op_code = op; opnd_a = a; opnd_b = b;
            @(negedge clk);
            check_bit("R7 valid", out_valid, 1'b1);
            check_eq("R7 random mix", res_data, ref_word(op, a, b));
        end
        in_valid = 1'b0;
        @(negedge clk);
        check_bit("R8 valid drops", out_valid, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule